// File: doc/BRIEF.md
# Two-Speed Start-Up Clock Controller

This block decides which oscillator clocks the core after a power-on reset or a wake from sleep. If the feature is enabled and the primary oscillator is a crystal, the core starts at once on the internal oscillator. In parallel, a start-up timer counts primary oscillator periods until the crystal is stable. The timer runs in the primary clock domain.

In the high-speed crystal mode with PLL, a lock wait follows the timer. When both are done, the controller moves the core to the primary clock through a break-before-make switch and sets a status bit that software can read. Software may put the core back to sleep while it is still on the internal clock. Software may also hold the core on the internal clock after the timer has expired.

If the primary source is not a crystal, no timer delay applies. If the feature is disabled, the core stays halted until the primary source is ready and then runs from it directly.

Top module: `tss_clock_ctrl`

## Requirements
- R1: While reset is asserted, and afterwards until `pwrt_done` is high, `run_mode` is 2'b00 (halted), `pri_status` is 0 and `clk_sel` is 0.
- R2: With `cfg_two_speed_en`=1 and a crystal `osc_mode` (0 low-power, 1 standard, 2 high-speed, 3 high-speed with PLL), `run_mode` becomes 2'b01 (internal run) within 3 internal clock cycles of `pwrt_done` rising, with `pri_status`=0.
- R3: In crystal modes, `clk_sel` rises no earlier than OST_CYCLES (default 1024) primary clock periods after the start event, and no more than 46 periods later than that.
- R4: In `osc_mode`=3, the handover is further delayed by PLL_LOCK_CYCLES internal clock cycles after the start-up timer expires.
- R5: After the handover, with no input change, `run_mode` is 2'b10 (primary run), `pri_status`=1 and `clk_sel`=1.
- R6: For `osc_mode` 4 to 7 (non-crystal sources), no timer delay applies. `run_mode` never shows 2'b01, and `clk_sel` rises within 40 primary periods.
- R7: With `cfg_two_speed_en`=0 and a crystal mode, `run_mode` stays 2'b00 until the timer expires and then goes to 2'b10, never passing through 2'b01.
- R8: A `sleep_req` pulse in internal run sets `run_mode` to 2'b11 (sleep) on the next clock with `pri_status`=0. A following `wake_evt` restarts the full timer count.
- R9: A `sleep_req` pulse in primary run clears `pri_status` on the next clock and returns `clk_sel` to 0 within 30 internal cycles.
- R10: While `hold_int`=1, the core stays in internal run on the internal clock after the timer expires. Releasing `hold_int` lets the handover complete.
- R11: `clk_core` never shows a high or low phase shorter than the shorter half period of the two source clocks, and the two clock enables are never on together.
- R12: `pri_status` is 1 only while `clk_sel` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | Internal oscillator clock, always running; control domain |
| clk_pri | input | 1 | Primary oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrt_done | input | 1 | Power-up timer has expired after power-on reset |
| wake_evt | input | 1 | One-cycle pulse: wake from sleep |
| sleep_req | input | 1 | One-cycle pulse: core requests sleep |
| cfg_two_speed_en | input | 1 | Configuration enable for two-speed start-up |
| osc_mode | input | 3 | Primary oscillator mode (0-3 crystal, 3 with PLL, 4-7 other) |
| hold_int | input | 1 | Software clock select: keep the core on the internal clock |
| clk_core | output | 1 | Glitch-free core clock |
| clk_sel | output | 1 | 1 when the primary clock is gated onto the core clock |
| pri_status | output | 1 | Software-visible status: primary oscillator drives the core |
| run_mode | output | 2 | 00 halted, 01 internal run, 10 primary run, 11 sleep |

## Verification
Some checks hold on every internal clock edge and are made by assertions. The two clock enables are never on together. The status bit implies the primary clock is selected and is clear in sleep and while halted. Internal run is entered only under a crystal mode with the feature enabled. The status bit rises only after the synchronized timer-done flag.

Other behaviour depends on counted spans and on sequences of events, so only the bench scenarios can show it. This covers the timer length in primary periods, the added PLL wait, the bypass for non-crystal sources, and the disabled path that never enters internal run. It also covers the timer restart after a sleep and wake, the effect of the hold input, and the minimum phase width of the switched clock.

// File: rtl/tss_pkg.sv
`timescale 1ns/1ps
package tss_pkg;

  typedef enum logic [1:0] {
    RM_HALT  = 2'b00,
    RM_INT   = 2'b01,
    RM_PRI   = 2'b10,
    RM_SLEEP = 2'b11
  } run_mode_e;

  typedef enum logic [2:0] {
    ST_POR,
    ST_INT_RUN,
    ST_HOLD,
    ST_PLL_WAIT,
    ST_SWITCH,
    ST_PRI_RUN,
    ST_SLEEP
  } ctrl_state_e;

  // modes 0..3 are crystal based, 3 adds a PLL
  function automatic logic is_crystal(input logic [2:0] mode);
    return (mode <= 3'd3);
  endfunction

  function automatic logic uses_pll(input logic [2:0] mode);
    return (mode == 3'd3);
  endfunction

  function automatic logic two_speed_on(input logic en, input logic [2:0] mode);
    return en && is_crystal(mode);
  endfunction

endpackage

// File: rtl/tss_sync.sv
`timescale 1ns/1ps
module tss_sync #(
  parameter bit RST_VAL = 1'b0,
  parameter int STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tss_ost_timer.sv
`timescale 1ns/1ps
module tss_ost_timer #(
  parameter int OST_CYCLES = 1024
) (
  input  logic clk_pri,
  input  logic rst_n,
  input  logic run_req,
  output logic done
);
  localparam int CW = (OST_CYCLES > 1) ? $clog2(OST_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(OST_CYCLES - 1);

  logic          run_s;
  logic [CW-1:0] cnt;

  tss_sync #(.RST_VAL(1'b0)) u_run_sync (
    .clk(clk_pri), .rst_n(rst_n), .d(run_req), .q(run_s)
  );

  always_ff @(posedge clk_pri or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!run_s) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      if (cnt == LAST) done <= 1'b1;
      else             cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tss_clk_switch.sv
`timescale 1ns/1ps
module tss_clk_switch (
  input  logic clk_int,
  input  logic clk_pri,
  input  logic rst_n,
  input  logic req_pri,
  output logic clk_core,
  output logic int_en,
  output logic pri_en,
  output logic pri_on_s
);
  logic int_want, int_want_s;
  logic pri_want, pri_want_s;

  // internal side releases only once the primary side is off
  assign int_want = !req_pri && !pri_en;
  assign pri_want = req_pri && !int_en;

  tss_sync #(.RST_VAL(1'b1)) u_int_sync (
    .clk(clk_int), .rst_n(rst_n), .d(int_want), .q(int_want_s)
  );
  tss_sync #(.RST_VAL(1'b0)) u_pri_sync (
    .clk(clk_pri), .rst_n(rst_n), .d(pri_want), .q(pri_want_s)
  );

  // enables change only while their own clock is low
  always_ff @(negedge clk_int or negedge rst_n) begin
    if (!rst_n) int_en <= 1'b1;
    else        int_en <= int_want_s;
  end

  always_ff @(negedge clk_pri or negedge rst_n) begin
    if (!rst_n) pri_en <= 1'b0;
    else        pri_en <= pri_want_s;
  end

  tss_sync #(.RST_VAL(1'b0)) u_on_sync (
    .clk(clk_int), .rst_n(rst_n), .d(pri_en), .q(pri_on_s)
  );

  assign clk_core = (clk_int & int_en) | (clk_pri & pri_en);
endmodule

// File: rtl/tss_ctrl.sv
`timescale 1ns/1ps
module tss_ctrl
  import tss_pkg::*;
#(
  parameter int PLL_LOCK_CYCLES = 16000
) (
  input  logic       clk_int,
  input  logic       rst_n,
  input  logic       pwrt_done,
  input  logic       wake_evt,
  input  logic       sleep_req,
  input  logic       cfg_en,
  input  logic [2:0] osc_mode,
  input  logic       hold_int,
  input  logic       ost_done_s,
  input  logic       pri_on_s,
  output logic       ost_run,
  output logic       req_pri,
  output logic       status,
  output logic [1:0] run_mode,
  output logic       start_evt
);
  localparam int PW = $clog2(PLL_LOCK_CYCLES + 1);
  localparam logic [PW-1:0] PLL_LAST = PW'(PLL_LOCK_CYCLES - 1);

  ctrl_state_e st, start_st;
  logic        ts_lat, pll_lat, wake_pend;
  logic [PW-1:0] pll_cnt;
  logic        ost_ready, sleep_go, core_on_int;

  always_comb begin
    if (!is_crystal(osc_mode))              start_st = ST_SWITCH;
    else if (two_speed_on(cfg_en, osc_mode)) start_st = ST_INT_RUN;
    else                                     start_st = ST_HOLD;
  end

  assign start_evt = (st == ST_POR && pwrt_done) ||
                     (st == ST_SLEEP && (wake_pend || wake_evt) &&
                      !ost_done_s && !pri_on_s);

  assign ost_ready = ost_done_s &&
                     (st == ST_HOLD || (st == ST_INT_RUN && !hold_int));

  assign core_on_int = ts_lat &&
                       (st == ST_INT_RUN || st == ST_PLL_WAIT || st == ST_SWITCH);

  assign sleep_go = sleep_req && (st == ST_PRI_RUN || core_on_int);

  always_ff @(posedge clk_int or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_POR;
      ts_lat    <= 1'b0;
      pll_lat   <= 1'b0;
      wake_pend <= 1'b0;
      pll_cnt   <= '0;
      ost_run   <= 1'b0;
      req_pri   <= 1'b0;
      status    <= 1'b0;
    end else if (start_evt) begin
      st        <= start_st;
      ts_lat    <= two_speed_on(cfg_en, osc_mode);
      pll_lat   <= uses_pll(osc_mode);
      wake_pend <= 1'b0;
      pll_cnt   <= '0;
      ost_run   <= is_crystal(osc_mode);
      req_pri   <= !is_crystal(osc_mode);
    end else if (sleep_go) begin
      st        <= ST_SLEEP;
      ost_run   <= 1'b0;
      req_pri   <= 1'b0;
      status    <= 1'b0;
      wake_pend <= 1'b0;
    end else begin
      case (st)
        ST_INT_RUN, ST_HOLD: begin
          if (ost_ready) begin
            if (pll_lat) st <= ST_PLL_WAIT;
            else begin
              st      <= ST_SWITCH;
              req_pri <= 1'b1;
            end
          end
        end
        ST_PLL_WAIT: begin
          if (pll_cnt != PLL_LAST) pll_cnt <= pll_cnt + 1'b1;
          else if (!(ts_lat && hold_int)) begin
            st      <= ST_SWITCH;
            req_pri <= 1'b1;
          end
        end
        ST_SWITCH: begin
          if (pri_on_s) begin
            st     <= ST_PRI_RUN;
            status <= 1'b1;
          end
        end
        ST_SLEEP: begin
          if (wake_evt) wake_pend <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (st)
      ST_INT_RUN:  run_mode = RM_INT;
      ST_PLL_WAIT,
      ST_SWITCH:   run_mode = ts_lat ? RM_INT : RM_HALT;
      ST_PRI_RUN:  run_mode = RM_PRI;
      ST_SLEEP:    run_mode = RM_SLEEP;
      default:     run_mode = RM_HALT;
    endcase
  end
endmodule

// File: rtl/tss_clock_ctrl.sv
`timescale 1ns/1ps
module tss_clock_ctrl #(
  parameter int OST_CYCLES      = 1024,
  parameter int PLL_LOCK_CYCLES = 16000
) (
  input  logic       clk_int,
  input  logic       clk_pri,
  input  logic       rst_n,
  input  logic       pwrt_done,
  input  logic       wake_evt,
  input  logic       sleep_req,
  input  logic       cfg_two_speed_en,
  input  logic [2:0] osc_mode,
  input  logic       hold_int,
  output logic       clk_core,
  output logic       clk_sel,
  output logic       pri_status,
  output logic [1:0] run_mode
);
  // named internal events, observed by the bound checker
  logic ost_run, ost_done, ost_done_s;
  logic req_pri, int_en, pri_en, pri_on_s;
  logic start_evt;

  tss_ost_timer #(.OST_CYCLES(OST_CYCLES)) u_ost (
    .clk_pri(clk_pri), .rst_n(rst_n), .run_req(ost_run), .done(ost_done)
  );

  tss_sync #(.RST_VAL(1'b0)) u_done_sync (
    .clk(clk_int), .rst_n(rst_n), .d(ost_done), .q(ost_done_s)
  );

  tss_ctrl #(.PLL_LOCK_CYCLES(PLL_LOCK_CYCLES)) u_ctrl (
    .clk_int(clk_int), .rst_n(rst_n), .pwrt_done(pwrt_done),
    .wake_evt(wake_evt), .sleep_req(sleep_req), .cfg_en(cfg_two_speed_en),
    .osc_mode(osc_mode), .hold_int(hold_int), .ost_done_s(ost_done_s),
    .pri_on_s(pri_on_s), .ost_run(ost_run), .req_pri(req_pri),
    .status(pri_status), .run_mode(run_mode), .start_evt(start_evt)
  );

  tss_clk_switch u_sw (
    .clk_int(clk_int), .clk_pri(clk_pri), .rst_n(rst_n), .req_pri(req_pri),
    .clk_core(clk_core), .int_en(int_en), .pri_en(pri_en), .pri_on_s(pri_on_s)
  );

  assign clk_sel = pri_on_s;
endmodule

// File: rtl/tss_checker.sv
`timescale 1ns/1ps
module tss_checker
  import tss_pkg::*;
(
  input logic       clk_int,
  input logic       rst_n,
  input logic       cfg_two_speed_en,
  input logic [2:0] osc_mode,
  input logic       clk_sel,
  input logic       pri_status,
  input logic [1:0] run_mode,
  input logic       int_en,
  input logic       pri_en,
  input logic       ost_done_s
);
  p_never_both_on_r11: assert property (@(posedge clk_int) disable iff (!rst_n)
    !(int_en && pri_en));

  p_status_needs_sel_r12: assert property (@(posedge clk_int) disable iff (!rst_n)
    pri_status |-> clk_sel);

  p_sleep_clears_status_r8: assert property (@(posedge clk_int) disable iff (!rst_n)
    (run_mode == RM_SLEEP) |-> !pri_status);

  p_halt_no_status_r1: assert property (@(posedge clk_int) disable iff (!rst_n)
    (run_mode == RM_HALT) |-> !pri_status);

  p_int_entry_gated_r2: assert property (@(posedge clk_int) disable iff (!rst_n)
    (run_mode == RM_INT && $past(run_mode) != RM_INT) |->
      ($past(cfg_two_speed_en) && is_crystal($past(osc_mode))));

  p_status_after_ost_r3: assert property (@(posedge clk_int) disable iff (!rst_n)
    ($rose(pri_status) && is_crystal(osc_mode)) |-> ost_done_s);
endmodule

bind tss_clock_ctrl tss_checker u_chk (
  .clk_int(clk_int), .rst_n(rst_n), .cfg_two_speed_en(cfg_two_speed_en),
  .osc_mode(osc_mode), .clk_sel(clk_sel), .pri_status(pri_status),
  .run_mode(run_mode), .int_en(int_en), .pri_en(pri_en),
  .ost_done_s(ost_done_s)
);

// File: tb/tss_clock_ctrl_tb.sv
`timescale 1ns/1ps
module tss_clock_ctrl_tb;
  localparam int PLL_T = 200;

  logic clk_int = 1'b0, clk_pri = 1'b0, rst_n = 1'b0;
  logic pwrt_done = 1'b0, wake_evt = 1'b0, sleep_req = 1'b0;
  logic cfg_en = 1'b0, hold_int = 1'b0;
  logic [2:0] osc_mode = 3'd0;
  logic clk_core, clk_sel, pri_status;
  logic [1:0] run_mode;

  int n_chk = 0, n_fail = 0;
  int int_cnt = 0, pri_cnt = 0;
  int glitch_err = 0, stat_err = 0;
  realtime last_edge = 0.0;

  always #5 clk_int = ~clk_int;   // 100 MHz
  always #3 clk_pri = ~clk_pri;

  tss_clock_ctrl #(.OST_CYCLES(1024), .PLL_LOCK_CYCLES(PLL_T)) u_dut (
    .clk_int(clk_int), .clk_pri(clk_pri), .rst_n(rst_n), .pwrt_done(pwrt_done),
    .wake_evt(wake_evt), .sleep_req(sleep_req), .cfg_two_speed_en(cfg_en),
    .osc_mode(osc_mode), .hold_int(hold_int), .clk_core(clk_core),
    .clk_sel(clk_sel), .pri_status(pri_status), .run_mode(run_mode)
  );

  always @(posedge clk_pri) pri_cnt <= pri_cnt + 1;

  // R11: phase width of the switched clock
  always @(clk_core) begin
    if (rst_n && last_edge > 0.0 && ($realtime - last_edge) < 2.9) glitch_err++;
    last_edge = $realtime;
  end

  // R12: status never without primary selection
  always @(negedge clk_int) if (rst_n && pri_status && !clk_sel) stat_err++;

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk_int) begin
    int_cnt <= int_cnt + 1;
    if (int_cnt > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected < 150000", int_cnt);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_int);
  endtask

  task automatic do_reset(input logic [2:0] mode, input logic en, input logic hold);
    @(negedge clk_int);
    rst_n = 1'b0; pwrt_done = 1'b0; osc_mode = mode; cfg_en = en; hold_int = hold;
    cyc(5);
    rst_n = 1'b1;
    cyc(5);
  endtask

  task automatic wait_mode(input logic [1:0] m, input int lim, output int took);
    took = 0;
    while (run_mode != m && took < lim) begin cyc(1); took++; end
  endtask

  task automatic wait_sel(input logic v, input int lim, output int took);
    took = 0;
    while (clk_sel != v && took < lim) begin cyc(1); took++; end
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; cyc(1); s = 1'b0;
  endtask

  // R1, R2, R3, R5
  task automatic t_two_speed(input logic [2:0] mode);
    int took, p0;
    do_reset(mode, 1'b1, 1'b0);
    chk(run_mode == 2'b00, "R1 run_mode in reset wait", run_mode, 0);
    chk(!pri_status && !clk_sel, "R1 status/sel in reset wait", pri_status, 0);
    pwrt_done = 1'b1;
    wait_mode(2'b01, 3, took);
    p0 = pri_cnt;
    chk(run_mode == 2'b01, "R2 internal run after pwrt", run_mode, 1);
    chk(pri_status == 1'b0, "R2 status while internal", pri_status, 0);
    wait_sel(1'b1, 5000, took);
    chk((pri_cnt - p0) >= 1024 && (pri_cnt - p0) <= 1070,
        "R3 primary periods to handover", pri_cnt - p0, 1024);
    wait_mode(2'b10, 10, took);
    cyc(2);
    chk(run_mode == 2'b10, "R5 primary run", run_mode, 2);
    chk(pri_status && clk_sel, "R5 status set", pri_status, 1);
  endtask

  // R4
  task automatic t_pll();
    int took, i0;
    do_reset(3'd3, 1'b1, 1'b0);
    pwrt_done = 1'b1;
    wait_mode(2'b01, 3, took);
    i0 = int_cnt;
    cyc(700);
    chk(run_mode == 2'b01 && !clk_sel, "R4 still internal during lock", run_mode, 1);
    wait_sel(1'b1, 5000, took);
    chk((int_cnt - i0) >= 815 && (int_cnt - i0) <= 880,
        "R4 internal cycles to handover with PLL", int_cnt - i0, 815);
  endtask

  // R6
  task automatic t_noncrystal();
    int p0, seen;
    do_reset(3'd5, 1'b1, 1'b0);
    pwrt_done = 1'b1;
    p0 = pri_cnt; seen = 0;
    for (int i = 0; i < 60 && !clk_sel; i++) begin
      cyc(1);
      if (run_mode == 2'b01) seen++;
    end
    chk(clk_sel && (pri_cnt - p0) <= 40, "R6 fast handover", pri_cnt - p0, 40);
    chk(seen == 0, "R6 no internal run", seen, 0);
  endtask

  // R7
  task automatic t_disabled();
    int p0, seen;
    do_reset(3'd1, 1'b0, 1'b0);
    pwrt_done = 1'b1;
    p0 = pri_cnt; seen = 0;
    for (int i = 0; i < 5000 && run_mode != 2'b10; i++) begin
      cyc(1);
      if (run_mode == 2'b01 || run_mode == 2'b11) seen++;
    end
    chk(seen == 0, "R7 halted during start-up", seen, 0);
    chk(run_mode == 2'b10 && (pri_cnt - p0) >= 1024, "R7 primary after timer",
        pri_cnt - p0, 1024);
  endtask

  // R8, R9
  task automatic t_sleep();
    int took, p0;
    do_reset(3'd0, 1'b1, 1'b0);
    pwrt_done = 1'b1;
    wait_mode(2'b01, 3, took);
    cyc(100);
    pulse(sleep_req);
    chk(run_mode == 2'b11 && !pri_status, "R8 sleep from internal run", run_mode, 3);
    cyc(50);
    chk(run_mode == 2'b11 && !clk_sel, "R8 remains asleep", run_mode, 3);
    pulse(wake_evt);
    wait_mode(2'b01, 10, took);
    p0 = pri_cnt;
    chk(run_mode == 2'b01, "R8 wake to internal run", run_mode, 1);
    wait_sel(1'b1, 5000, took);
    chk((pri_cnt - p0) >= 1024, "R8 timer restarted after wake", pri_cnt - p0, 1024);
    wait_mode(2'b10, 10, took);
    cyc(2);
    pulse(sleep_req);
    chk(run_mode == 2'b11 && !pri_status, "R9 status cleared by sleep", pri_status, 0);
    wait_sel(1'b0, 30, took);
    chk(!clk_sel, "R9 selection back to internal", clk_sel, 0);
  endtask

  // R10
  task automatic t_hold();
    int took;
    do_reset(3'd2, 1'b1, 1'b1);
    pwrt_done = 1'b1;
    cyc(1500);
    chk(run_mode == 2'b01 && !clk_sel && !pri_status, "R10 held on internal",
        run_mode, 1);
    hold_int = 1'b0;
    wait_mode(2'b10, 30, took);
    chk(run_mode == 2'b10, "R10 handover after release", run_mode, 2);
  endtask

  initial begin
    t_two_speed(3'd0);
    t_two_speed(3'd2);
    t_pll();
    t_noncrystal();
    t_disabled();
    t_sleep();
    t_hold();
    chk(glitch_err == 0, "R11 short clock phases", glitch_err, 0);
    chk(stat_err == 0, "R12 status without primary", stat_err, 0);
    finish_run();
  end
endmodule